// File: doc/BRIEF.md
# Walking-One Loopback Pin Tester

This block exercises two banks of I/O pins that are jumpered together in pairs by an external loopback fixture. At any moment it drives a single pin high and keeps every other pin released, so the pad pulldowns hold those pins low. After a settle delay it samples the opposite bank and checks that only the partner of the driven pin reads high. It first walks a one across every bank A pin while watching bank B. It then reverses direction, and each bank B partner drives in turn while bank A is watched.

The walk runs for as long as no fault appears. A pass flag rises once a full round in both directions has completed without a fault. On the first mismatch the walk freezes. The block then raises an error flag and holds an 8-bit code that names the failing step. Codes run consecutively through the round, so a single code identifies both the driving pin and the receiving pin. One contiguous group of pins is wired in mirrored order on the fixture, and the block accounts for that when it picks the partner.

Top module: `loopback_walker`

## Requirements
- R1: Out of reset and while no fault is latched, exactly one bit of the combined vector {oe_b, oe_a} is 1. The output value of every pin equals its enable, so the single enabled pin is driven high.
- R2: In the forward phase, step j (0 ≤ j < NPINS) enables bank A pin j. The step passes only if the synchronized bank B input equals a one-hot vector at partner(j), with every other bank B pin low.
- R3: In the reverse phase, step j enables bank B pin partner(j) and checks that the synchronized bank A input is one-hot at pin j. The reverse phase starts after forward step NPINS-1 passes, and the forward phase starts again after reverse step NPINS-1 passes.
- R4: partner(i) = 2*MIR_BASE + MIR_W - 1 - i when MIR_BASE ≤ i < MIR_BASE+MIR_W, and i otherwise. With the defaults (120 pins, base 64, width 22), A pin 64 pairs with B pin 85.
- R5: Bank inputs pass through two flops. Each step lasts SETTLE cycles (default 4) and is judged in its last cycle, so step k of the round (k = 0 for the first forward step) is judged on the cycle that ends at rising edge 4(k+1) after reset is released.
- R6: The walk repeats without end. The pass output rises at the edge that completes the last reverse step of the first round and then stays high while no fault occurs.
- R7: On the first failing step, err rises at the edge that ends that step. The walk then freezes: the enables, err and err_code all hold until reset.
- R8: err_code is j for a failure at forward step j and NPINS + j for a failure at reverse step j. With the defaults these are 0x00–0x77 and 0x78–0xEF.
- R9: A fault clears pass, even if pass had already been set.
- R10: While reset is held (synchronous, active high), pass = 0, err = 0, err_code = 0, and the walk sits at forward step 0 with only oe_a[0] set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| oe_a | output | NPINS | Bank A pad output enables |
| out_a | output | NPINS | Bank A pad output values |
| oe_b | output | NPINS | Bank B pad output enables |
| out_b | output | NPINS | Bank B pad output values |
| in_a | input | NPINS | Bank A pad inputs |
| in_b | input | NPINS | Bank B pad inputs |
| pass | output | 1 | A full round completed with no fault |
| err | output | 1 | A fault was found; the walk is frozen |
| err_code | output | 8 | Index of the failing step within the round |

## Verification
The bench models the fixture with breakable links in each direction, a stuck-high pin, and an option to wire the mirrored group straight. A tester that paired the mirrored group straight would accept that miswired fixture and fail the correct one at code 0x40. A tester that only checked the partner bit would miss the stuck-high neighbour. A tester that numbered reverse codes from zero would report 0x03 instead of 0x7B for a broken B-to-A link. The bench also injects a fault after pass has risen, to confirm that pass drops and that the frozen drive and code stay held long after the fault.

// File: rtl/loopback_walker.sv
module loopback_walker #(
  parameter int NPINS    = 120,
  parameter int MIR_BASE = 64,
  parameter int MIR_W    = 22,
  parameter int SETTLE   = 4
) (
  input  logic             clk,
  input  logic             rst,
  output logic [NPINS-1:0] oe_a,
  output logic [NPINS-1:0] out_a,
  output logic [NPINS-1:0] oe_b,
  output logic [NPINS-1:0] out_b,
  input  logic [NPINS-1:0] in_a,
  input  logic [NPINS-1:0] in_b,
  output logic             pass,
  output logic             err,
  output logic [7:0]       err_code
);
  localparam int IW = (NPINS > 1) ? $clog2(NPINS) : 1;
  localparam int CW = $clog2(SETTLE + 1);
  localparam logic [NPINS-1:0] ONE = {{(NPINS-1){1'b0}}, 1'b1};

  logic          rev;
  logic [IW-1:0] idx;
  logic [IW-1:0] pidx;
  logic [CW-1:0] cnt;
  logic [NPINS-1:0] sa1, sa2, sb1, sb2;
  logic [NPINS-1:0] hot_i, hot_p;
  logic last, match, wrap;

  assign pidx  = (int'(idx) >= MIR_BASE && int'(idx) < MIR_BASE + MIR_W)
               ? IW'(2*MIR_BASE + MIR_W - 1 - int'(idx)) : idx;
  assign hot_i = ONE << idx;
  assign hot_p = ONE << pidx;

  assign oe_a  = rev ? '0 : hot_i;
  assign oe_b  = rev ? hot_p : '0;
  assign out_a = oe_a;
  assign out_b = oe_b;

  assign last  = (cnt == CW'(SETTLE - 1));
  assign match = rev ? (sa2 == hot_i) : (sb2 == hot_p);
  assign wrap  = (idx == IW'(NPINS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      sa1 <= '0; sa2 <= '0; sb1 <= '0; sb2 <= '0;
    end else begin
      sa1 <= in_a; sa2 <= sa1;
      sb1 <= in_b; sb2 <= sb1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rev <= 1'b0; idx <= '0; cnt <= '0;
      pass <= 1'b0; err <= 1'b0; err_code <= '0;
    end else if (!err) begin
      if (!last) begin
        cnt <= cnt + 1'b1;
      end else if (match) begin
        cnt <= '0;
        if (wrap) begin
          idx <= '0;
          rev <= ~rev;
          if (rev) pass <= 1'b1;
        end else begin
          idx <= idx + 1'b1;
        end
      end else begin
        err      <= 1'b1;
        pass     <= 1'b0;
        err_code <= rev ? 8'(NPINS + int'(idx)) : 8'(idx);
      end
    end
  end

  assert_one_driver_R1: assert property (@(posedge clk) disable iff (rst)
    !err |-> $countones({oe_b, oe_a}) == 1);
  assert_fault_frozen_R7: assert property (@(posedge clk) disable iff (rst)
    err |=> err && $stable(err_code) && $stable(oe_a) && $stable(oe_b));
  assert_pass_at_round_end_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(pass) |-> !rev && idx == '0 && !err);
  assert_fault_clears_pass_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> !pass);
  assert_step_on_last_cycle_R5: assert property (@(posedge clk) disable iff (rst)
    (!last && !err) |=> $stable(idx) && $stable(rev));
endmodule

// File: tb/test_loopback_walker.sv
module test_loopback_walker;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 120;
  localparam int MB = 64;
  localparam int MW = 22;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] oe_a, out_a, oe_b, out_b, in_a, in_b;
  logic pass, err;
  logic [7:0] err_code;

  logic [N-1:0] brk_ab, brk_ba, stuck_b;
  logic straight;
  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  loopback_walker i_loopback_walker (
    .clk(clk), .rst(rst), .oe_a(oe_a), .out_a(out_a), .oe_b(oe_b), .out_b(out_b),
    .in_a(in_a), .in_b(in_b), .pass(pass), .err(err), .err_code(err_code));

  function automatic int mate(input int i);
    if (!straight && i >= MB && i < MB + MW) return MB + (MB + MW - 1 - i);
    return i;
  endfunction

  always_comb begin
    in_a = '0;
    in_b = stuck_b;
    for (int i = 0; i < N; i++) begin
      if (oe_a[i] && out_a[i] && !brk_ab[i]) in_b[mate(i)] = 1'b1;
      if (oe_b[mate(i)] && out_b[mate(i)] && !brk_ba[i]) in_a[i] = 1'b1;
    end
  end

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic start();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // advance to the negedge following rising edge k after reset release
  int edges;
  task automatic to_edge(input int k);
    while (edges < k) begin
      @(posedge clk);
      edges++;
    end
    @(negedge clk);
  endtask

  task automatic setup(input logic str);
    brk_ab = '0; brk_ba = '0; stuck_b = '0; straight = str;
    start();
    edges = 0;
  endtask

  function automatic logic [N-1:0] hot(input int i);
    return {{(N-1){1'b0}}, 1'b1} << i;
  endfunction

  task automatic t_reset();
    brk_ab = '0; brk_ba = '0; stuck_b = '0; straight = 1'b0;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 pass", N'(pass), N'(0));
    check("R10 err", N'(err), N'(0));
    check("R10 code", N'(err_code), N'(0));
    check("R10 oe_a", oe_a, hot(0));
    check("R10 oe_b", oe_b, '0);
  endtask

  task automatic t_clean_round();
    setup(1'b0);
    to_edge(4*5 + 2);
    check("R2 forward step 5 drive", oe_a, hot(5));
    check("R1 out_a follows enable", out_a, hot(5));
    check("R1 no B drive in forward", oe_b, '0);
    to_edge(4*64 + 2);
    check("R4 forward step 64", oe_a, hot(64));
    to_edge(4*120 + 2);
    check("R3 reverse step 0", oe_b, hot(0));
    check("R3 no A drive in reverse", oe_a, '0);
    to_edge(4*(120+64) + 2);
    check("R4 reverse step 64 drives B85", oe_b, hot(85));
    check("R1 out_b follows enable", out_b, hot(85));
    to_edge(959);
    check("R6 pass low before round end", N'(pass), N'(0));
    to_edge(960);
    check("R6 pass at round end", N'(pass), N'(1));
    check("R6 walk restarts forward", oe_a, hot(0));
    to_edge(1500);
    check("R6 pass stays", N'(pass), N'(1));
    check("R6 no error on clean fixture", N'(err), N'(0));
  endtask

  task automatic t_open_forward();
    setup(1'b0);
    brk_ab[10] = 1'b1;
    to_edge(43);
    check("R5 no error before step end", N'(err), N'(0));
    to_edge(44);
    check("R7 err at step end", N'(err), N'(1));
    check("R8 forward code", N'(err_code), N'(8'h0A));
    to_edge(400);
    check("R7 code held", N'(err_code), N'(8'h0A));
    check("R7 drive frozen", oe_a, hot(10));
    check("R9 pass low", N'(pass), N'(0));
  endtask

  task automatic t_stuck_high();
    setup(1'b0);
    stuck_b[5] = 1'b1;
    to_edge(4);
    check("R2 extra high pin fails", N'(err), N'(1));
    check("R8 code step 0", N'(err_code), N'(8'h00));
  endtask

  task automatic t_straight_mirror();
    setup(1'b1);
    to_edge(4*64);
    check("R4 group before mirror ok", N'(err), N'(0));
    to_edge(4*65);
    check("R4 straight wiring fails", N'(err), N'(1));
    check("R4 code 0x40", N'(err_code), N'(8'h40));
  endtask

  task automatic t_open_reverse();
    setup(1'b0);
    brk_ba[3] = 1'b1;
    to_edge(4*123 + 2);
    check("R3 no error before reverse step 3 ends", N'(err), N'(0));
    to_edge(4*124);
    check("R3 reverse fault", N'(err), N'(1));
    check("R8 reverse code", N'(err_code), N'(8'h7B));
    check("R7 frozen B drive", oe_b, hot(3));
  endtask

  task automatic t_fault_after_pass();
    setup(1'b0);
    to_edge(965);
    check("R6 pass before late fault", N'(pass), N'(1));
    brk_ba[100] = 1'b1;
    to_edge(4*461 - 1);
    check("R9 pass until fault", N'(pass), N'(1));
    to_edge(4*461);
    check("R9 pass cleared by fault", N'(pass), N'(0));
    check("R8 code 0xDC", N'(err_code), N'(8'hDC));
  endtask

  initial begin
    t_reset();
    t_clean_round();
    t_open_forward();
    t_stuck_high();
    t_straight_mirror();
    t_open_reverse();
    t_fault_after_pass();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule